// File: doc/BRIEF.md
# DMA Interrupt Hub with Software Reset

This block is the shared control register set of a multichannel DMA engine. Each channel signals the end of a block transfer with a one-cycle pulse on its bit of `chan_evt`. The hub records that pulse as a pending bit in four separate interrupt groups. Each group has its own pending word and its own mask word, with one bit per channel, and drives one interrupt line. A line is raised whenever any pending bit in its group is also unmasked. Software clears pending bits by writing ones to them.

The hub also holds a global configuration field that sets the burst length. It offers a software-requested reset. Software sets the request bit, polls a completion bit until it reads 1, and then reprograms the hub. While the reset runs, the hub ignores register writes and channel pulses.

Registers are written through a single-cycle write strobe. They are read through a combinational read port that has its own address.

Top module: `dmairq_hub`

## Requirements
- R1: After the reset input is released, every pending word (addresses 0-3) and every mask word (addresses 4-7) reads 0. The global configuration (address 10) reads 0, the control word (address 9) reads 0, the status word (address 8) reads 1, and all four interrupt lines are low.
- R2: A pulse on a bit of `chan_evt` sets that channel's bit in the pending word of all four groups on the next clock edge, whether or not the channel is unmasked.
- R3: Writing to pending word j (address j) clears exactly the bits written as 1. Bits written as 0 keep their value, and the other groups are untouched.
- R4: Mask word j (address 4+j) holds the value last written to it and reads it back unchanged.
- R5: Interrupt line j is high in the cycle after its pending word and mask word share a set bit. It goes low one cycle after no such bit remains.
- R6: When a channel pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: Writing bit 1 = 1 to the control word starts a software reset that lasts 8 cycles. During those cycles, control bit 1 reads 1 and status bit 0 reads 0. Afterwards, control bit 1 reads 0 and status bit 0 reads 1.
- R8: A software reset sets every pending word, every mask word and the global configuration to 0, and drives all interrupt lines low for its whole duration.
- R9: While a software reset is running, register writes and channel pulses have no effect. Writes take effect again once the reset completes.
- R10: The global configuration (address 10) stores the low 8 bits of the written data and reads 0 in bits 31:8.
- R11: A read from any unmapped address (11-15) returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Combinational read data |
| chan_evt | input | 32 | Per-channel end-of-block pulses |
| irq | output | 4 | Interrupt line per group |

## Verification
Two functions can act on one pending bit in the same cycle: a channel pulse setting it and a write-one-to-clear write aimed at it. The bench provokes this with a table entry that drives the write strobe and the pulse together. One overlapping bit is pulsed while a second written bit is not pulsed. The read-back must show the pulsed bit still set and the other bit cleared. A second collision happens between the software reset and traffic arriving during it. Writes and pulses are injected while the reset runs, and all registers are then checked for zero after completion.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  // Word address map of the register port
  localparam int ADR_PEND_BASE = 0;   // pending words, one per group
  localparam int ADR_MASK_BASE = 4;   // mask words, one per group
  localparam int ADR_STAT      = 8;   // status: completion bit
  localparam int ADR_CTRL      = 9;   // control: reset request bit
  localparam int ADR_GCFG      = 10;  // global burst configuration

  // Bit positions software depends on
  localparam int STAT_DONE_BIT = 0;
  localparam int CTRL_SRST_BIT = 1;
endpackage

// File: rtl/dmairq_softrst.sv
module dmairq_softrst #(
  parameter int RST_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  logic [CNT_W-1:0] remain;

  // The start pulse loads RST_CYC-1 and busy then lasts exactly RST_CYC cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= CNT_W'(RST_CYC - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/dmairq_line.sv
module dmairq_line #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclr,
  input  logic [NCH-1:0] evt,
  input  logic [NCH-1:0] clr,
  input  logic           mask_we,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] mask,
  output logic           line
);
  // An event outranks a clear on the same bit
  function automatic logic [NCH-1:0] pend_next(input logic [NCH-1:0] cur,
                                               input logic [NCH-1:0] wipe,
                                               input logic [NCH-1:0] hit);
    return (cur & ~wipe) | hit;
  endfunction

  function automatic logic line_hit(input logic [NCH-1:0] p,
                                    input logic [NCH-1:0] m);
    return |(p & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '0;
      line <= 1'b0;
    end else if (sclr) begin
      pend <= '0;
      mask <= '0;
      line <= 1'b0;
    end else begin
      pend <= pend_next(pend, clr, evt);
      if (mask_we) mask <= wdata;
      line <= line_hit(pend, mask);
    end
  end
endmodule

// File: rtl/dmairq_rdmux.sv
module dmairq_rdmux
  import dmairq_pkg::*;
#(
  parameter int NLINE  = 4,
  parameter int NCH    = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int GCFG_W = 8
) (
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [NLINE-1:0][NCH-1:0]  pend_all,
  input  logic [NLINE-1:0][NCH-1:0]  mask_all,
  input  logic                       busy,
  input  logic [GCFG_W-1:0]          gcfg,
  output logic [DATA_W-1:0]          rd_data
);
  always_comb begin
    rd_data = '0;
    for (int j = 0; j < NLINE; j++) begin
      if (rd_addr == ADDR_W'(ADR_PEND_BASE + j)) rd_data = DATA_W'(pend_all[j]);
      if (rd_addr == ADDR_W'(ADR_MASK_BASE + j)) rd_data = DATA_W'(mask_all[j]);
    end
    if (rd_addr == ADDR_W'(ADR_STAT)) rd_data[STAT_DONE_BIT] = ~busy;
    if (rd_addr == ADDR_W'(ADR_CTRL)) rd_data[CTRL_SRST_BIT] = busy;
    if (rd_addr == ADDR_W'(ADR_GCFG)) rd_data = DATA_W'(gcfg);
  end
endmodule

// File: rtl/dmairq_hub.sv
module dmairq_hub
  import dmairq_pkg::*;
#(
  parameter int NLINE   = 4,
  parameter int NCH     = 32,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int GCFG_W  = 8,
  parameter int RST_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NCH-1:0]    chan_evt,
  output logic [NLINE-1:0]  irq
);
  // Named internal events for the checker
  logic                      soft_busy;
  logic                      soft_start;
  logic                      soft_clr;
  logic                      wr_ok;
  logic [NLINE-1:0][NCH-1:0] clr_all;
  logic [NLINE-1:0][NCH-1:0] pend_all;
  logic [NLINE-1:0][NCH-1:0] mask_all;
  logic [GCFG_W-1:0]         gcfg;

  assign wr_ok      = wr_en & ~soft_busy;
  assign soft_start = wr_ok && (wr_addr == ADDR_W'(ADR_CTRL)) && wr_data[CTRL_SRST_BIT];
  assign soft_clr   = soft_start | soft_busy;

  dmairq_softrst #(.RST_CYC(RST_CYC)) u_srst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (soft_start),
    .busy  (soft_busy)
  );

  for (genvar j = 0; j < NLINE; j++) begin : g_line
    logic pend_we;
    logic mask_we;
    assign pend_we    = wr_ok && (wr_addr == ADDR_W'(ADR_PEND_BASE + j));
    assign mask_we    = wr_ok && (wr_addr == ADDR_W'(ADR_MASK_BASE + j));
    assign clr_all[j] = pend_we ? wr_data[NCH-1:0] : '0;

    dmairq_line #(.NCH(NCH)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclr    (soft_clr),
      .evt     (chan_evt),
      .clr     (clr_all[j]),
      .mask_we (mask_we),
      .wdata   (wr_data[NCH-1:0]),
      .pend    (pend_all[j]),
      .mask    (mask_all[j]),
      .line    (irq[j])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      gcfg <= '0;
    else if (soft_clr)                               gcfg <= '0;
    else if (wr_ok && wr_addr == ADDR_W'(ADR_GCFG))  gcfg <= wr_data[GCFG_W-1:0];
  end

  dmairq_rdmux #(
    .NLINE(NLINE), .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GCFG_W(GCFG_W)
  ) u_rd (
    .rd_addr  (rd_addr),
    .pend_all (pend_all),
    .mask_all (mask_all),
    .busy     (soft_busy),
    .gcfg     (gcfg),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/dmairq_hub_chk.sv
module dmairq_hub_chk #(
  parameter int NLINE   = 4,
  parameter int NCH     = 32,
  parameter int RST_CYC = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      busy,
  input logic                      sclr,
  input logic [NCH-1:0]            evt,
  input logic [NLINE-1:0][NCH-1:0] clr_all,
  input logic [NLINE-1:0][NCH-1:0] pend_all,
  input logic [NLINE-1:0][NCH-1:0] mask_all,
  input logic [NLINE-1:0]          irq
);
  localparam int LEN_W = $clog2(RST_CYC + 2) + 1;
  logic [LEN_W-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  // R7: reset window length
  assert_srst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == LEN_W'(RST_CYC));

  for (genvar j = 0; j < NLINE; j++) begin : g_chk
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclr && |evt) |=> ((pend_all[j] & $past(evt)) == $past(evt)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclr && |clr_all[j]) |=> ((pend_all[j] & $past(clr_all[j] & ~evt)) == '0));

    assert_evt_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclr && |(evt & clr_all[j])) |=>
        ((pend_all[j] & $past(evt & clr_all[j])) == $past(evt & clr_all[j])));

    assert_line_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sclr |=> (irq[j] == |($past(pend_all[j]) & $past(mask_all[j]))));

    assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (pend_all[j] == '0 && mask_all[j] == '0 && !irq[j]));
  end
endmodule

bind dmairq_hub dmairq_hub_chk #(.NLINE(NLINE), .NCH(NCH), .RST_CYC(RST_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (soft_busy),
  .sclr     (soft_clr),
  .evt      (chan_evt),
  .clr_all  (clr_all),
  .pend_all (pend_all),
  .mask_all (mask_all),
  .irq      (irq)
);

// File: tb/dmairq_hub_bench.sv
module dmairq_hub_bench;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2, OP_WE = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [31:0] evt;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{OP_WR, 4'd4,  32'h0000_00F0, 32'h0,  32'h0,          4'd4},  // R4 mask0
    '{OP_RD, 4'd4,  32'h0,         32'h0,  32'h0000_00F0,  4'd4},  // R4
    '{OP_EV, 4'd0,  32'h0,         32'h11, 32'h0,          4'd2},  // R2 pulse
    '{OP_RD, 4'd0,  32'h0,         32'h0,  32'h0000_0011,  4'd2},  // R2 group 0
    '{OP_RD, 4'd3,  32'h0,         32'h0,  32'h0000_0011,  4'd2},  // R2 masked group 3
    '{OP_WR, 4'd0,  32'h0000_0001, 32'h0,  32'h0,          4'd3},  // R3 clear bit 0
    '{OP_RD, 4'd0,  32'h0,         32'h0,  32'h0000_0010,  4'd3},  // R3
    '{OP_RD, 4'd3,  32'h0,         32'h0,  32'h0000_0011,  4'd3},  // R3 other group
    '{OP_WE, 4'd3,  32'h0000_0011, 32'h01, 32'h0,          4'd6},  // R6 collision
    '{OP_RD, 4'd3,  32'h0,         32'h0,  32'h0000_0001,  4'd6},  // R6
    '{OP_WR, 4'd10, 32'hFFFF_FF41, 32'h0,  32'h0,          4'd10}, // R10
    '{OP_RD, 4'd10, 32'h0,         32'h0,  32'h0000_0041,  4'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] chan_evt = '0;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  dmairq_hub u_dmairq_hub (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .chan_evt(chan_evt), .irq(irq)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic we, input logic [3:0] a, input logic [31:0] d,
                       input logic [31:0] e);
    wr_en = we; wr_addr = a; wr_data = d; chan_evt = e;
    cyc();
    wr_en = 1'b0; chan_evt = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a;
    #0.5;
    chk(tag, rd_data, exp);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1 pend/mask", 4'(a), 32'h0);
    rd("R1 status", 4'd8, 32'h1);
    rd("R1 control", 4'd9, 32'h0);
    rd("R1 gcfg", 4'd10, 32'h0);
    chk("R1 irq", {28'h0, irq}, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR: drive(1'b1, VEC[i].addr, VEC[i].data, 32'h0);
        OP_EV: drive(1'b0, VEC[i].addr, 32'h0, VEC[i].evt);
        OP_WE: drive(1'b1, VEC[i].addr, VEC[i].data, VEC[i].evt);
        default: rd($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].addr, VEC[i].exp);
      endcase
    end

    // R11 unmapped reads
    for (int a = 11; a < 16; a++) rd("R11 unmapped", 4'(a), 32'h0);

    // R5: pend0=0x11, mask0=0xF0 -> line 0 high, line 3 unmasked nothing
    chk("R5 line0 high", {31'h0, irq[0]}, 32'h1);
    chk("R5 line3 low", {31'h0, irq[3]}, 32'h0);
    drive(1'b1, 4'd0, 32'h0000_0011, 32'h0);
    chk("R5 line0 lags clear", {31'h0, irq[0]}, 32'h1);
    cyc();
    chk("R5 line0 falls", {31'h0, irq[0]}, 32'h0);
    drive(1'b0, 4'd0, 32'h0, 32'h0000_0020);
    chk("R5 line0 lags event", {31'h0, irq[0]}, 32'h0);
    cyc();
    chk("R5 line0 rises", {31'h0, irq[0]}, 32'h1);

    // R7 R8 R9 software reset
    drive(1'b1, 4'd9, 32'h0000_0002, 32'h0);
    rd("R7 done low", 4'd8, 32'h0);
    rd("R7 request reads 1", 4'd9, 32'h2);
    chk("R8 irq low", {28'h0, irq}, 32'h0);
    drive(1'b1, 4'd5, 32'h0000_00AA, 32'h0);   // ignored write
    drive(1'b0, 4'd0, 32'h0, 32'hFFFF_FFFF);   // ignored pulses
    repeat (5) cyc();
    rd("R7 still running", 4'd8, 32'h0);
    cyc();
    rd("R7 done high", 4'd8, 32'h1);
    rd("R7 request cleared", 4'd9, 32'h0);
    rd("R9 write ignored", 4'd5, 32'h0);
    rd("R9 pulses ignored", 4'd1, 32'h0);
    rd("R8 pend0 cleared", 4'd0, 32'h0);
    rd("R8 mask0 cleared", 4'd4, 32'h0);
    rd("R8 gcfg cleared", 4'd10, 32'h0);
    chk("R8 irq after", {28'h0, irq}, 32'h0);
    drive(1'b1, 4'd5, 32'h0000_0003, 32'h0);
    rd("R9 writes resume", 4'd5, 32'h3);

    finish_run();
  end
endmodule